// File: doc/BRIEF.md
# Quarter-Rate Bit-Stream Down-Mixer and Complex Weighter

This block serves one antenna element and one beam of a digital beamformer. It takes the raw, undecimated output of a bandpass noise-shaping converter. That output is a five-level stream, and the converter is centred on one quarter of the sample rate. Because of that centre frequency, the local oscillator needs only the values -1, 0 and +1. Down-conversion to baseband I/Q is therefore a three-way choice among passing the sample, forcing zero and negating it.

The mixed value still lies in {-2..+2}. It is multiplied by a stored complex weight through a five-way choice: negate, zero, pass, double, or negated double. In every cycle only one of the two mixed components is non-zero. The two terms of the complex product therefore never need to be added. A pair of 2:1 selects routes the single non-zero term to each output. A summation tree placed after the block adds the phase-shifted I and Q words of all elements.

Top module: `bsr_rotator`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_valid is 0, out_i and out_q are 0, and the local-oscillator phase restarts at phase 0. The stored weights are cleared to 0 by reset.
- R2: in_sample is a 3-bit two's-complement code. Codes 110, 111, 000, 001 and 010 mean -2, -1, 0, +1 and +2. Codes 011, 100 and 101 are taken as 0, so both outputs for such a sample are 0.
- R3: A 2-bit phase counter advances by one on every valid sample and wraps from 3 to 0. The cosine is +1, 0, -1, 0 and the sine is 0, +1, 0, -1 for phases 0, 1, 2 and 3.
- R4: The mixed components are I = x·cos and Q = x·sin, where x is the decoded sample value.
- R5: When wt_load is 1, wt_re_in and wt_im_in (6-bit signed) are stored at the clock edge. A code of -32 is stored as -31, so the stored range is -31..+31.
- R6: out_i = I·Wr − Q·Wi and out_q = I·Wi + Q·Wr, as 7-bit signed words, never beyond ±62.
- R7: The results of a valid sample appear on out_i and out_q one clock later. out_valid equals in_valid delayed by one clock.
- R8: While in_valid is 0, out_i and out_q hold their last values and the phase does not advance.
- R9: When a weight load and a valid sample fall in the same cycle, that sample is weighted with the previously stored weight. The new weight applies from the next sample on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | in_sample carries a sample this cycle |
| in_sample | input | 3 | Five-level sample, two's complement |
| wt_load | input | 1 | Store wt_re_in and wt_im_in at this edge |
| wt_re_in | input | 6 | Real part of the complex weight, signed |
| wt_im_in | input | 6 | Imaginary part of the complex weight, signed |
| out_valid | output | 1 | out_i and out_q carry a new result |
| out_i | output | 7 | Phase-shifted in-phase word, signed |
| out_q | output | 7 | Phase-shifted quadrature word, signed |

## Verification
A weight load and a valid sample can land on the same clock edge. The block must then weight that sample with the old pair and keep the new pair for the samples that follow. The bench drives both strobes in one cycle with clearly different old and new weights, and compares that result with the old-weight product. It then compares the next sample with the new-weight product, with the phase counter tracked in the bench's own model.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

   typedef logic signed [2:0] level_t;

   typedef enum logic [1:0] {
      PH_0   = 2'd0,
      PH_90  = 2'd1,
      PH_180 = 2'd2,
      PH_270 = 2'd3
   } lo_phase_e;

   // five legal codes, everything else is read as zero
   function automatic level_t decode_level(input logic [2:0] code);
      level_t v;
      case (code)
         3'b110, 3'b111, 3'b000, 3'b001, 3'b010: v = level_t'(code);
         default:                                v = '0;
      endcase
      return v;
   endfunction

   function automatic level_t flip_level(input level_t l);
      level_t v;
      case (l)
         3'sd1:   v = -3'sd1;
         3'sd2:   v = -3'sd2;
         -3'sd1:  v = 3'sd1;
         -3'sd2:  v = 3'sd2;
         default: v = '0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/bsr_lo_phase.sv
module bsr_lo_phase
   import bsr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      adv,
   output lo_phase_e phase
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= PH_0;
      else if (adv)
         phase <= lo_phase_e'(phase + 2'd1);
   end

   // R3
   phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (2'(phase) == 2'($past(phase) + 2'd1)));

   // R8
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(phase));

endmodule

// File: rtl/bsr_mixer.sv
module bsr_mixer
   import bsr_pkg::*;
(
   input  logic [2:0] sample,
   input  lo_phase_e  phase,
   output level_t     mix_i,
   output level_t     mix_q,
   output logic       on_q
);

   level_t x;
   level_t x_neg;

   assign x     = decode_level(sample);
   assign x_neg = flip_level(x);

   // three-way select per component: pass, zero, negate
   always_comb begin
      case (phase)
         PH_0:    begin mix_i = x;     mix_q = '0;    end
         PH_90:   begin mix_i = '0;    mix_q = x;     end
         PH_180:  begin mix_i = x_neg; mix_q = '0;    end
         default: begin mix_i = '0;    mix_q = x_neg; end
      endcase
   end

   assign on_q = phase[0];

   // R4
   always_comb begin
      alt_zero_chk: assert (mix_i == '0 || mix_q == '0);
   end

endmodule

// File: rtl/bsr_weight_mult.sv
module bsr_weight_mult
   import bsr_pkg::*;
#(
   parameter int WEIGHT_W = 6,
   localparam int PROD_W  = WEIGHT_W + 1
) (
   input  level_t                     lvl,
   input  logic signed [WEIGHT_W-1:0] weight,
   output logic signed [PROD_W-1:0]   prod
);

   logic signed [PROD_W-1:0] w_ext;
   logic signed [PROD_W-1:0] w_dbl;

   assign w_ext = {weight[WEIGHT_W-1], weight};
   assign w_dbl = {weight, 1'b0};

   // five-way select: negate, zero, pass, shift, negated shift
   always_comb begin
      case (lvl)
         3'sd1:   prod = w_ext;
         3'sd2:   prod = w_dbl;
         -3'sd1:  prod = -w_ext;
         -3'sd2:  prod = -w_dbl;
         default: prod = '0;
      endcase
   end

   // R6
   always_comb begin
      if (lvl == '0) zero_prod_chk: assert (prod == '0);
   end

endmodule

// File: rtl/bsr_rotator.sv
module bsr_rotator
   import bsr_pkg::*;
#(
   parameter int WEIGHT_W = 6,
   localparam int PROD_W  = WEIGHT_W + 1,
   localparam int W_MAX   = (1 << (WEIGHT_W - 1)) - 1,
   localparam int P_MAX   = 2 * W_MAX
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic [2:0]                 in_sample,
   input  logic                       wt_load,
   input  logic signed [WEIGHT_W-1:0] wt_re_in,
   input  logic signed [WEIGHT_W-1:0] wt_im_in,
   output logic                       out_valid,
   output logic signed [PROD_W-1:0]   out_i,
   output logic signed [PROD_W-1:0]   out_q
);

   initial begin
      weight_w_ok: assert (WEIGHT_W >= 2 && WEIGHT_W <= 16);
   end

   localparam logic signed [WEIGHT_W-1:0] W_MIN_CODE = {1'b1, {(WEIGHT_W-1){1'b0}}};
   localparam logic signed [WEIGHT_W-1:0] W_CLAMP    = {1'b1, {(WEIGHT_W-2){1'b0}}, 1'b1};

   lo_phase_e phase;
   level_t    mix_i, mix_q, lvl, lvl_n;
   logic      on_q;

   logic signed [WEIGHT_W-1:0] w_store [2];
   logic signed [WEIGHT_W-1:0] w_in    [2];
   logic signed [WEIGHT_W-1:0] w_sel   [2];
   level_t                     l_sel   [2];
   logic signed [PROD_W-1:0]   p_sel   [2];

   bsr_lo_phase u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (in_valid),
      .phase (phase)
   );

   bsr_mixer u_mix (
      .sample (in_sample),
      .phase  (phase),
      .mix_i  (mix_i),
      .mix_q  (mix_q),
      .on_q   (on_q)
   );

   assign lvl   = on_q ? mix_q : mix_i;
   assign lvl_n = flip_level(lvl);
   assign w_in[0] = wt_re_in;
   assign w_in[1] = wt_im_in;

   // index 0: real part / I' path, index 1: imaginary part / Q' path
   for (genvar k = 0; k < 2; k++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            w_store[k] <= '0;
         else if (wt_load)
            w_store[k] <= (w_in[k] == W_MIN_CODE) ? W_CLAMP : w_in[k];
      end

      // R5
      w_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         w_store[k] != W_MIN_CODE);

      bsr_weight_mult #(.WEIGHT_W(WEIGHT_W)) u_mult (
         .lvl    (l_sel[k]),
         .weight (w_sel[k]),
         .prod   (p_sel[k])
      );
   end

   // 2:1 selects replace the complex-product adders
   assign w_sel[0] = on_q ? w_store[1] : w_store[0];
   assign l_sel[0] = on_q ? lvl_n      : lvl;
   assign w_sel[1] = on_q ? w_store[0] : w_store[1];
   assign l_sel[1] = lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_i     <= '0;
         out_q     <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_i <= p_sel[0];
            out_q <= p_sel[1];
         end
      end
   end

   // R7
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R7
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R8
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_i) && $stable(out_q)));

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_i <= P_MAX && out_i >= -P_MAX && out_q <= P_MAX && out_q >= -P_MAX));

endmodule

// File: tb/bsr_rotator_test.sv
module bsr_rotator_test;

   localparam int CLK_PERIOD = 10;
   localparam int N_VEC = 12;

   // {weight real, weight imag, sample code}
   localparam logic [14:0] VEC [N_VEC] = '{
      {6'd5,  6'd3,  3'b001},
      {6'd12, 6'd9,  3'b010},
      {6'd31, 6'd1,  3'b111},
      {6'd0,  6'd17, 3'b110},
      {6'd50, 6'd20, 3'b001},
      {6'd33, 6'd63, 3'b010},
      {6'd8,  6'd40, 3'b110},
      {6'd31, 6'd31, 3'b010},
      {6'd1,  6'd33, 3'b111},
      {6'd44, 6'd2,  3'b000},
      {6'd22, 6'd11, 3'b010},
      {6'd63, 6'd30, 3'b110}
   };

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                in_valid = 1'b0;
   logic [2:0]          in_sample = '0;
   logic                wt_load = 1'b0;
   logic signed [5:0]   wt_re_in = '0;
   logic signed [5:0]   wt_im_in = '0;
   logic                out_valid;
   logic signed [6:0]   out_i;
   logic signed [6:0]   out_q;

   int checks = 0;
   int errors = 0;
   int m_ph = 0, m_wr = 0, m_wi = 0, e_i = 0, e_q = 0, e_v = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bsr_rotator uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .wt_load(wt_load), .wt_re_in(wt_re_in), .wt_im_in(wt_im_in),
      .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
   );

   function automatic int dec(input logic [2:0] c);
      int v = int'($signed(c));
      if (v > 2 || v < -2) v = 0;
      return v;
   endfunction

   function automatic int wclamp(input logic [5:0] c);
      int v = int'($signed(c));
      if (v == -32) v = -31;
      return v;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic [2:0] code, input logic ld,
                       input logic [5:0] wr, input logic [5:0] wi);
      int x, c, s, mi, mq;
      @(negedge clk);
      in_valid = v; in_sample = code; wt_load = ld; wt_re_in = wr; wt_im_in = wi;
      @(posedge clk);
      #1;
      e_v = int'(v);
      if (v) begin
         x = dec(code);
         c = (m_ph == 0) ? 1 : (m_ph == 2) ? -1 : 0;
         s = (m_ph == 1) ? 1 : (m_ph == 3) ? -1 : 0;
         mi = x * c; mq = x * s;
         e_i = mi * m_wr - mq * m_wi;
         e_q = mi * m_wi + mq * m_wr;
         m_ph = (m_ph + 1) % 4;
      end
      if (ld) begin
         m_wr = wclamp(wr);
         m_wi = wclamp(wi);
      end
   endtask

   task automatic check_out(input string tag);
      chk({tag, " out_valid"}, int'(out_valid), e_v);
      chk({tag, " out_i"}, int'(out_i), e_i);
      chk({tag, " out_q"}, int'(out_q), e_q);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 out_valid", int'(out_valid), 0);
      chk("R1 out_i", int'(out_i), 0);
      chk("R1 out_q", int'(out_q), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // table walk: load cycle (R8 hold, R5), then sample cycle (R4 R6 R7)
      for (int n = 0; n < N_VEC; n++) begin
         step(1'b0, VEC[n][2:0], 1'b1, VEC[n][14:9], VEC[n][8:3]);
         check_out("R8 load-idle");
         step(1'b1, VEC[n][2:0], 1'b0, '0, '0);
         check_out("R6 vector");
      end

      // R3: four phases in a row with +1 input
      step(1'b0, 3'b000, 1'b1, 6'd7, 6'd19);
      for (int k = 0; k < 4; k++) begin
         step(1'b1, 3'b001, 1'b0, '0, '0);
         check_out("R3 phase");
      end

      // R2: unused codes read as zero
      step(1'b1, 3'b011, 1'b0, '0, '0);
      check_out("R2 code 3");
      step(1'b1, 3'b100, 1'b0, '0, '0);
      check_out("R2 code -4");
      step(1'b1, 3'b101, 1'b0, '0, '0);
      check_out("R2 code -3");

      // R5: -32 stored as -31, full-scale product
      step(1'b0, 3'b000, 1'b1, 6'b100000, 6'b100000);
      for (int k = 0; k < 4; k++) begin
         step(1'b1, 3'b010, 1'b0, '0, '0);
         check_out("R5 clamp");
      end

      // R9: load and sample in the same cycle
      step(1'b0, 3'b000, 1'b1, 6'd3, 6'd2);
      step(1'b1, 3'b010, 1'b1, 6'd29, 6'd27);
      check_out("R9 old weight");
      step(1'b1, 3'b010, 1'b0, '0, '0);
      check_out("R9 new weight");

      // R8: idle cycles hold outputs
      step(1'b0, 3'b010, 1'b0, '0, '0);
      check_out("R8 idle");
      step(1'b0, 3'b110, 1'b0, '0, '0);
      check_out("R8 idle2");

      // R1: reset mid-run clears weights and phase
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      m_ph = 0; m_wr = 0; m_wi = 0; e_i = 0; e_q = 0; e_v = 0;
      check_out("R1 mid reset");
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b1, 3'b010, 1'b0, '0, '0);
      check_out("R1 weights cleared");
      step(1'b0, 3'b000, 1'b1, 6'd9, 6'd4);
      step(1'b1, 3'b001, 1'b0, '0, '0);
      check_out("R1 phase restart");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule